// File: doc/BRIEF.md
# DMA address generator with ring wrap

This block keeps the read and write addresses of one DMA channel. A load strobe sets both addresses to new starting values. Each advance strobe then moves each address forward by the transfer size, in bytes, if that side has its increment flag set. Transfer counting, bus signalling, buffering and pacing stay outside the block.

One side can be held inside a ring. The ring is a naturally aligned region of 2^n bytes. Only the low n address bits roll over, and the upper bits stay frozen, which suits circular buffers. A select bit picks which side uses the ring. The other side always counts linearly.

The block also passes each data beat through an optional byte reorder that depends on the transfer size. The reorder is combinational, so the reordered beat appears in the same cycle as its input.

Top module: `dma_addr_ring_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, rd_addr and wr_addr are both 0.
- R2: After a clock edge with load high, rd_addr equals rd_start and wr_addr equals wr_start. This holds even when step is also high in that cycle.
- R3: After a clock edge with step high, load low and the side's increment flag set, that address grows by the step size. Outside a ring it grows modulo 2^ADDR_W. The step size is 1 for xfer_size 0 (byte), 2 for 1 (halfword) and 4 for 2 or 3 (word).
- R4: A side whose increment flag is clear keeps its address across a step.
- R5: With step and load both low, both addresses keep their values.
- R6: With ring_log2 = n > 0, the ring applies to the read side when ring_wr_side is 0 and to the write side when it is 1. On a step, the ringed address keeps bits n and above, and its low n bits become (low bits + step size) mod 2^n.
- R7: The side that the ring does not select steps linearly, as in R3, whatever ring_log2 is.
- R8: ring_log2 = 0 disables wrapping on both sides.
- R9: A ringed side whose increment flag is clear holds its address.
- R10: With swap_en low, beat_out equals beat_in.
- R11: With swap_en high, beat_out depends on xfer_size. For a byte (0), beat_in is unchanged. For a halfword (1), the two bytes inside each 16-bit half are exchanged. For a word (2 or 3), all four bytes are reversed. In every case the result appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Take rd_start and wr_start as the new addresses |
| rd_start | input | ADDR_W | Initial read address |
| wr_start | input | ADDR_W | Initial write address |
| step | input | 1 | Advance both sides by one transfer |
| xfer_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| rd_incr | input | 1 | Read address increments when set |
| wr_incr | input | 1 | Write address increments when set |
| ring_log2 | input | RING_W | Ring size exponent, 0 means no ring |
| ring_wr_side | input | 1 | 0 rings the read side, 1 rings the write side |
| swap_en | input | 1 | Enable the byte reorder |
| beat_in | input | DATA_W | Data beat to reorder |
| rd_addr | output | ADDR_W | Current read address |
| wr_addr | output | ADDR_W | Current write address |
| beat_out | output | DATA_W | Reordered data beat |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, RING_W = 4 and DATA_W = 32. With these values every ring size from 2 bytes (n = 1) to 32768 bytes (n = 15) can be reached. The tests also cover a linear address running past 0xFFFFFFFF and back to 0, and a word reversal across a full 32-bit beat. The reference model works out ring wrapping with integer modulo arithmetic rather than bit masks.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2,
        XS_WORD_ALT = 2'd3
    } xfer_size_e;

    localparam int unsigned SIDES = 2;
    localparam int unsigned SIDE_RD = 0;
    localparam int unsigned SIDE_WR = 1;
endpackage

// File: rtl/dag_ring_mask.sv
module dag_ring_mask #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned RING_W = 4
) (
    input  logic [RING_W-1:0] ring_log2,
    input  logic              ringed,
    output logic [ADDR_W-1:0] roll_mask
);
    logic wrap_active;
    assign wrap_active = ringed && (ring_log2 != '0);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign roll_mask[i] = !wrap_active || (i < int'(ring_log2));
    end
endmodule

// File: rtl/dag_next_addr.sv
module dag_next_addr #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] start,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] roll_mask,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] summed;
    assign summed = cur + stride;

    always_comb begin
        if (load) begin
            nxt = start;
        end else if (adv) begin
            nxt = (cur & ~roll_mask) | (summed & roll_mask);
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/dag_byte_swap.sv
module dag_byte_swap
    import dag_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        xfer_size,
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned NB = DATA_W / 8;

    logic [DATA_W-1:0] half_sw;
    logic [DATA_W-1:0] full_rev;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign half_sw[8*k +: 8]  = din[8*(k ^ 1) +: 8];
        assign full_rev[8*k +: 8] = din[8*(NB-1-k) +: 8];
    end

    always_comb begin
        dout = din;
        if (swap_en) begin
            case (xfer_size_e'(xfer_size))
                XS_BYTE:  dout = din;
                XS_HALF:  dout = half_sw;
                default:  dout = full_rev;
            endcase
        end
    end
endmodule

// File: rtl/dma_addr_ring_gen.sv
module dma_addr_ring_gen
    import dag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned RING_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] rd_start,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic              step,
    input  logic [1:0]        xfer_size,
    input  logic              rd_incr,
    input  logic              wr_incr,
    input  logic [RING_W-1:0] ring_log2,
    input  logic              ring_wr_side,
    input  logic              swap_en,
    input  logic [DATA_W-1:0] beat_in,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] beat_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] wr;
    } addr_state_t;

    addr_state_t state_d, state_q;

    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] cur_a   [SIDES];
    logic [ADDR_W-1:0] start_a [SIDES];
    logic              incr_a  [SIDES];
    logic              ring_a  [SIDES];
    logic [ADDR_W-1:0] mask_a  [SIDES];
    logic [ADDR_W-1:0] nxt_a   [SIDES];

    always_comb begin
        case (xfer_size_e'(xfer_size))
            XS_BYTE: stride = ADDR_W'(1);
            XS_HALF: stride = ADDR_W'(2);
            default: stride = ADDR_W'(4);
        endcase
    end

    assign cur_a[SIDE_RD]   = state_q.rd;
    assign cur_a[SIDE_WR]   = state_q.wr;
    assign start_a[SIDE_RD] = rd_start;
    assign start_a[SIDE_WR] = wr_start;
    assign incr_a[SIDE_RD]  = rd_incr;
    assign incr_a[SIDE_WR]  = wr_incr;
    assign ring_a[SIDE_RD]  = !ring_wr_side;
    assign ring_a[SIDE_WR]  = ring_wr_side;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dag_ring_mask #(.ADDR_W(ADDR_W), .RING_W(RING_W)) mask_i (
            .ring_log2 (ring_log2),
            .ringed    (ring_a[s]),
            .roll_mask (mask_a[s])
        );
        dag_next_addr #(.ADDR_W(ADDR_W)) next_i (
            .cur       (cur_a[s]),
            .start     (start_a[s]),
            .load      (load),
            .adv       (step && incr_a[s]),
            .stride    (stride),
            .roll_mask (mask_a[s]),
            .nxt       (nxt_a[s])
        );
    end

    always_comb begin
        state_d    = state_q;
        state_d.rd = nxt_a[SIDE_RD];
        state_d.wr = nxt_a[SIDE_WR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_addr = state_q.rd;
    assign wr_addr = state_q.wr;

    dag_byte_swap #(.DATA_W(DATA_W)) swap_i (
        .xfer_size (xfer_size),
        .swap_en   (swap_en),
        .din       (beat_in),
        .dout      (beat_out)
    );
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned RING_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [ADDR_W-1:0] rd_start,
    input logic [ADDR_W-1:0] wr_start,
    input logic              step,
    input logic [1:0]        xfer_size,
    input logic              rd_incr,
    input logic              wr_incr,
    input logic [RING_W-1:0] ring_log2,
    input logic              ring_wr_side,
    input logic              swap_en,
    input logic [DATA_W-1:0] beat_in,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] beat_out
);
    logic [ADDR_W-1:0] chk_stride;
    logic [ADDR_W-1:0] chk_hi;

    always_comb begin
        chk_stride = (xfer_size == 2'd0) ? ADDR_W'(1) :
                     (xfer_size == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
        chk_hi = ~((ADDR_W'(1) << ring_log2) - ADDR_W'(1));
    end

    // R2
    load_takes_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rd_addr == $past(rd_start)) && (wr_addr == $past(wr_start)));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && rd_incr)) |=> $stable(rd_addr));

    // R3
    wr_linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && wr_incr && ring_log2 == '0) |=>
            (wr_addr == $past(wr_addr) + $past(chk_stride)));

    // R6
    rd_ring_upper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && rd_incr && !ring_wr_side && ring_log2 != '0) |=>
            ((rd_addr & $past(chk_hi)) == ($past(rd_addr) & $past(chk_hi))));

    // R10
    always_comb begin
        if (rst_n && !swap_en) begin
            swap_off_pass_chk: assert (beat_out == beat_in);
        end
    end
endmodule

bind dma_addr_ring_gen dag_chk #(
    .ADDR_W(ADDR_W), .RING_W(RING_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/dma_addr_ring_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_ring_gen_tb_top;
    localparam int AW = 32;
    localparam int RW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load;
    logic [AW-1:0] rd_start, wr_start;
    logic          step;
    logic [1:0]    xfer_size;
    logic          rd_incr, wr_incr;
    logic [RW-1:0] ring_log2;
    logic          ring_wr_side;
    logic          swap_en;
    logic [DW-1:0] beat_in;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] beat_out;

    int checks = 0;
    int fails  = 0;
    longint exp_rd = 0;
    longint exp_wr = 0;

    always #5 clk = ~clk;

    dma_addr_ring_gen #(.ADDR_W(AW), .RING_W(RW), .DATA_W(DW)) dut_i (.*);

    function automatic longint advance_one(longint a, bit inc, bit ringed);
        longint st;
        longint sz;
        if (!inc) return a;
        st = (xfer_size == 2'd0) ? 1 : (xfer_size == 2'd1) ? 2 : 4;
        if (ringed && ring_log2 != 0) begin
            sz = longint'(1) << ring_log2;
            return (a - (a % sz)) + (((a % sz) + st) % sz);
        end
        return (a + st) % (longint'(1) << 32);
    endfunction

    function automatic logic [31:0] model_swap(logic [31:0] d);
        logic [31:0] r;
        if (!swap_en || xfer_size == 2'd0) return d;
        if (xfer_size == 2'd1) r = {d[23:16], d[31:24], d[7:0], d[15:8]};
        else r = {d[7:0], d[15:8], d[23:16], d[31:24]};
        return r;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        if (!rst_n) begin
            exp_rd = 0;
            exp_wr = 0;
        end else if (load) begin
            exp_rd = longint'(rd_start);
            exp_wr = longint'(wr_start);
        end else if (step) begin
            exp_rd = advance_one(exp_rd, rd_incr, !ring_wr_side);
            exp_wr = advance_one(exp_wr, wr_incr, ring_wr_side);
        end
        @(negedge clk);
        check({tag, " rd_addr"}, longint'(rd_addr), exp_rd);
        check({tag, " wr_addr"}, longint'(wr_addr), exp_wr);
        check({tag, " beat_out"}, longint'(beat_out), longint'(model_swap(beat_in)));
    endtask

    task automatic do_load(logic [AW-1:0] r, logic [AW-1:0] w, string tag);
        load = 1'b1; rd_start = r; wr_start = w;
        cyc(tag);
        load = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; rd_start = '0; wr_start = '0; step = 1'b0;
        xfer_size = 2'd2; rd_incr = 1'b1; wr_incr = 1'b1; ring_log2 = '0;
        ring_wr_side = 1'b0; swap_en = 1'b0; beat_in = 32'h11223344;
        // R1 reset state
        repeat (3) cyc("R1 reset");
        rst_n = 1'b1;
        cyc("R1 after reset");

        // R2 load wins over step
        step = 1'b1;
        do_load(32'h0000_1000, 32'h0000_2000, "R2 load with step");
        step = 1'b0;

        // R3 byte, halfword, word steps
        step = 1'b1;
        xfer_size = 2'd0; repeat (3) cyc("R3 byte");
        xfer_size = 2'd1; repeat (3) cyc("R3 half");
        xfer_size = 2'd2; repeat (3) cyc("R3 word");
        xfer_size = 2'd3; repeat (2) cyc("R3 word alt");

        // R4 increment flags clear, one side at a time
        rd_incr = 1'b0; repeat (2) cyc("R4 rd held");
        rd_incr = 1'b1; wr_incr = 1'b0; repeat (2) cyc("R4 wr held");
        wr_incr = 1'b1;

        // R5 idle
        step = 1'b0; repeat (3) cyc("R5 idle");

        // R6/R7 16-byte read ring, write linear
        do_load(32'h0000_10F8, 32'h0000_30F8, "R2 reload");
        step = 1'b1; xfer_size = 2'd2; ring_log2 = 4'd4; ring_wr_side = 1'b0;
        repeat (6) cyc("R6 R7 read ring 16");

        // R6 2-byte write ring with byte steps
        do_load(32'hABCD_0001, 32'hABCD_0101, "R2 reload");
        step = 1'b1; ring_wr_side = 1'b1; ring_log2 = 4'd1; xfer_size = 2'd0;
        repeat (4) cyc("R6 R7 write ring 2");

        // R6 largest ring on write
        do_load(32'h0001_0000, 32'h1234_7FFC, "R2 reload");
        step = 1'b1; ring_log2 = 4'd15; xfer_size = 2'd2;
        repeat (3) cyc("R6 write ring 32768");

        // R9 ringed side not incrementing
        wr_incr = 1'b0; repeat (3) cyc("R9 ring held");
        wr_incr = 1'b1;

        // R8 no ring, full address rollover on both sides
        do_load(32'hFFFF_FFF8, 32'hFFFF_FFFC, "R2 reload");
        step = 1'b1; ring_log2 = 4'd0;
        repeat (3) cyc("R8 no wrap rollover");

        // R10 swap disabled; R11 sizes
        step = 1'b0;
        swap_en = 1'b0; beat_in = 32'hA1B2C3D4; xfer_size = 2'd2; cyc("R10 swap off");
        swap_en = 1'b1;
        xfer_size = 2'd0; cyc("R11 byte");
        xfer_size = 2'd1; cyc("R11 half");
        xfer_size = 2'd2; cyc("R11 word");
        xfer_size = 2'd3; beat_in = 32'h0F1E2D3C; cyc("R11 word alt");
        xfer_size = 2'd1; beat_in = 32'hFF00_00FF; cyc("R11 half edge");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule